// File: doc/BRIEF.md
# Stereo Volume Stage with Zero-Cross Commit

This block scales a stereo stream of signed PCM samples by a gain that software sets for each channel. The gain is a 6-bit code in 1 dB steps. Code 0 gives -57 dB, code 57 gives unity gain and code 63 gives +6 dB. Each channel also has a mute bit and a zero-cross enable bit. Both are written through a small register port.

A new volume code is first held as pending. It becomes active only when some write sets the update flag. That write may go to either channel's register, and it commits the pending codes of both channels together. A channel with zero-cross enabled does not switch gain on the commit itself. It waits until its own signal crosses zero, or until a sample-count timeout runs out. Samples enter with a valid strobe and leave one cycle later. Results are rounded and clipped to full scale.

Top module: `stereo_vol_zc`

## Requirements
- R1: After reset every channel has volume code 57, mute and zero-cross are cleared, and `out_valid`, `out_left` and `out_right` are 0. At code 57 the output sample equals the input sample.
- R2: A write to address 54 selects the left channel and address 55 the right channel. In the data word, bit 8 is update, bit 7 is zero-cross enable, bit 6 is mute and bits 5:0 are the volume code. A write to any other address has no effect.
- R3: A volume write with bit 8 clear does not change the gain that either channel applies.
- R4: A write with bit 8 set, to either address, commits the pending volume codes of both channels. This includes the code carried by that same write.
- R5: On a commit, a channel whose zero-cross enable is 0 uses its new code from the first sample after the write cycle. A sample presented in the write cycle itself still uses the old code.
- R6: On a commit, a channel whose zero-cross enable is 1 keeps its old code until a crossing sample arrives, and the crossing sample already uses the new code. A crossing sample is one equal to zero, or one whose sign differs from that channel's previous sample. The previous sample is 0 after reset. A new commit replaces any target still waiting.
- R7: If TIMEOUT samples (default 4096) arrive after a zero-cross commit and none of them crosses, the TIMEOUT-th sample uses the new code.
- R8: Mute and zero-cross enable take effect from the cycle after their write, whatever the update bit says. While mute is 1 the channel outputs 0. Clearing mute restores the scaled output.
- R9: The multiplier for code c is round(4096 * 10^((c-57)/20)). The output is floor((x*m + 2048) / 4096).
- R10: A result above the signed full-scale maximum or below the minimum is clipped to that limit, not wrapped.
- R11: `out_valid` follows `in_valid` one cycle later. The outputs hold their value when no sample arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (7) | Register address |
| wr_data | input | 9 | Register write data |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | W (16) | Left input sample, signed |
| in_right | input | W (16) | Right input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | W (16) | Left output sample, signed |
| out_right | output | W (16) | Right output sample, signed |

## Verification
Two events can land in the same clock edge. A register write, which may be a commit, can arrive together with a sample. A waiting channel's crossing sample can also arrive together with a fresh commit. The bench drives a sample in the very cycle of a commit write and checks that this sample keeps the old gain. It also sends a crossing sample in the same cycle as a new zero-cross commit. There the crossing sample must take the old target, and the channel must then wait again for the newly written code. The scoreboard model works each cycle in a fixed order: sample first, then write. Every output sample is compared against that order.

// File: rtl/stereo_vol_zc.sv
module stereo_vol_zc #(
  parameter int W       = 16,
  parameter int AW      = 7,
  parameter int TIMEOUT = 4096,
  parameter int ADDR_L  = 54,
  parameter int ADDR_R  = 55
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [8:0]          wr_data,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_left,
  input  logic signed [W-1:0] in_right,
  output logic                out_valid,
  output logic signed [W-1:0] out_left,
  output logic signed [W-1:0] out_right
);
  localparam int CW = $clog2(TIMEOUT) + 1;
  localparam int PW = W + 17;
  localparam logic signed [PW-1:0] PMAX = PW'((64'sd1 <<< (W-1)) - 1);
  localparam logic signed [PW-1:0] PMIN = -PMAX - 1;

  function automatic logic [15:0] gain_of(int code);
    real g;
    g = 4096.0 * (10.0 ** ((code - 57) / 20.0));
    return 16'($rtoi(g + 0.5));
  endfunction

  logic [15:0] lut [64];
  for (genvar i = 0; i < 64; i++) begin : g_lut
    assign lut[i] = gain_of(i);
  end

  logic [5:0] pend [2], act [2], tgt [2], pn [2], gsel [2];
  logic       zc [2], mute [2], armed [2], sel [2], zn [2], hit [2];
  logic [CW-1:0] cnt [2];
  logic signed [W-1:0]  xin [2], prev [2], ysat [2], yq [2];
  logic signed [PW-1:0] prod [2], rnd [2];

  assign xin[0] = in_left;
  assign xin[1] = in_right;
  assign sel[0] = wr_en && (wr_addr == AW'(ADDR_L));
  assign sel[1] = wr_en && (wr_addr == AW'(ADDR_R));
  wire commit = (sel[0] || sel[1]) && wr_data[8];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign pn[c]   = sel[c] ? wr_data[5:0] : pend[c];
    assign zn[c]   = sel[c] ? wr_data[7] : zc[c];
    assign hit[c]  = armed[c] && (!zc[c] || xin[c] == '0 ||
                     xin[c][W-1] != prev[c][W-1] || cnt[c] == CW'(TIMEOUT - 1));
    assign gsel[c] = hit[c] ? tgt[c] : act[c];
    assign prod[c] = PW'(xin[c]) * PW'($signed({1'b0, lut[gsel[c]]}));
    assign rnd[c]  = (prod[c] + PW'(2048)) >>> 12;
    assign ysat[c] = (rnd[c] > PMAX) ? PMAX[W-1:0] :
                     (rnd[c] < PMIN) ? PMIN[W-1:0] : rnd[c][W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        pend[c] <= 6'd57; act[c] <= 6'd57; tgt[c] <= 6'd57;
        zc[c] <= 1'b0; mute[c] <= 1'b0; armed[c] <= 1'b0;
        cnt[c] <= '0; prev[c] <= '0; yq[c] <= '0;
      end
    end else begin
      out_valid <= in_valid;
      for (int c = 0; c < 2; c++) begin
        if (in_valid) begin
          prev[c] <= xin[c];
          yq[c]   <= mute[c] ? '0 : ysat[c];
          if (hit[c]) begin
            act[c]   <= tgt[c];
            armed[c] <= 1'b0;
          end else if (armed[c]) begin
            cnt[c] <= cnt[c] + 1'b1;
          end
        end
        if (sel[c]) begin
          pend[c] <= wr_data[5:0];
          zc[c]   <= wr_data[7];
          mute[c] <= wr_data[6];
        end
        if (commit) begin
          if (!zn[c]) begin
            act[c]   <= pn[c];
            armed[c] <= 1'b0;
          end else begin
            tgt[c]   <= pn[c];
            armed[c] <= 1'b1;
            cnt[c]   <= '0;
          end
        end
      end
    end
  end

  assign out_left  = yq[0];
  assign out_right = yq[1];
endmodule

// File: rtl/stereo_vol_zc_chk.sv
module stereo_vol_zc_chk #(
  parameter int W       = 16,
  parameter int AW      = 7,
  parameter int TIMEOUT = 4096,
  parameter int ADDR_L  = 54
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [AW-1:0]       wr_addr,
  input logic                upd,
  input logic                zce,
  input logic [5:0]          vol,
  input logic                in_valid,
  input logic                out_valid,
  input logic signed [W-1:0] out_left,
  input logic                mute_l,
  input logic [5:0]          act_l,
  input logic [5:0]          act_r,
  input logic                armed_l,
  input logic                armed_r,
  input logic [$clog2(TIMEOUT):0] cnt_l
);
  a_r11_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mute_l |=> out_left == '0);
  a_r3_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !upd && !armed_l && !armed_r |=> $stable(act_l) && $stable(act_r));
  a_r5_direct_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == AW'(ADDR_L) && upd && !zce |=> act_l == $past(vol));
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed_l |-> cnt_l < ($clog2(TIMEOUT) + 1)'(TIMEOUT));
endmodule

bind stereo_vol_zc stereo_vol_zc_chk #(.W(W), .AW(AW), .TIMEOUT(TIMEOUT), .ADDR_L(ADDR_L)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .upd(wr_data[8]), .zce(wr_data[7]), .vol(wr_data[5:0]),
  .in_valid(in_valid), .out_valid(out_valid), .out_left(out_left),
  .mute_l(mute[0]), .act_l(act[0]), .act_r(act[1]),
  .armed_l(armed[0]), .armed_r(armed[1]), .cnt_l(cnt[0])
);

// File: tb/stereo_vol_zc_tb_top.sv
module stereo_vol_zc_tb_top;
  localparam int W = 16, AW = 7, TO = 4096;
  logic clk = 0, rst_n = 0, wr_en = 0, in_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [8:0] wr_data = '0;
  logic signed [W-1:0] in_left = '0, in_right = '0;
  logic out_valid;
  logic signed [W-1:0] out_left, out_right;
  int checks = 0, fails = 0;
  bit done = 0;
  string cur = "R1";

  always #5 clk = ~clk;

  stereo_vol_zc #(.W(W), .AW(AW), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right));

  int m_pend[2], m_act[2], m_tgt[2], m_cnt[2], m_prev[2];
  bit m_zc[2], m_mute[2], m_armed[2];
  int ql[$], qr[$];
  string qt[$];

  function automatic int gain(int code);
    return $rtoi(4096.0 * (10.0 ** ((code - 57) / 20.0)) + 0.5);
  endfunction

  function automatic int scale(int x, int code);
    longint p;
    p = (longint'(x) * gain(code) + 2048) >>> 12;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  function automatic int wd(bit u, bit z, bit m, int v);
    return (int'(u) << 8) | (int'(z) << 7) | (int'(m) << 6) | (v & 63);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit iv, int l, int r, bit we, int a, int d);
    int x, code, y[2];
    bit hit, s[2];
    @(negedge clk);
    in_valid = iv; in_left = W'(l); in_right = W'(r);
    wr_en = we; wr_addr = AW'(a); wr_data = 9'(d);
    for (int c = 0; c < 2; c++) begin
      if (iv) begin
        x = c ? r : l;
        hit = m_armed[c] && (!m_zc[c] || x == 0 || ((x < 0) != (m_prev[c] < 0)) || m_cnt[c] == TO - 1);
        code = hit ? m_tgt[c] : m_act[c];
        y[c] = m_mute[c] ? 0 : scale(x, code);
        if (hit) begin m_act[c] = m_tgt[c]; m_armed[c] = 0; end
        else if (m_armed[c]) m_cnt[c]++;
        m_prev[c] = x;
      end
    end
    if (iv) begin ql.push_back(y[0]); qr.push_back(y[1]); qt.push_back(cur); end
    s[0] = we && a == 54;
    s[1] = we && a == 55;
    for (int c = 0; c < 2; c++)
      if (s[c]) begin m_pend[c] = d & 63; m_zc[c] = d[7]; m_mute[c] = d[6]; end
    if ((s[0] || s[1]) && d[8])
      for (int c = 0; c < 2; c++)
        if (!m_zc[c]) begin m_act[c] = m_pend[c]; m_armed[c] = 0; end
        else begin m_tgt[c] = m_pend[c]; m_armed[c] = 1; m_cnt[c] = 0; end
  endtask

  task automatic smp(int l, int r); cyc(1, l, r, 0, 0, 0); endtask
  task automatic wr(int a, int d); cyc(0, 0, 0, 1, a, d); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (ql.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 actual=out_valid expected=no_output");
      end else begin
        string t;
        t = qt.pop_front();
        check(t, int'(out_left), ql.pop_front());
        check(t, int'(out_right), qr.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_pend[c] = 57; m_act[c] = 57; m_tgt[c] = 57; m_cnt[c] = 0; m_prev[c] = 0;
      m_zc[c] = 0; m_mute[c] = 0; m_armed[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_left), 0);
    check("R1", int'(out_right), 0);
    cur = "R1"; smp(1000, -1000); smp(-32768, 32767);
    idle();
    @(negedge clk);
    check("R11", int'(out_valid), 0);
    check("R11", int'(out_left), -32768);

    cur = "R2"; wr(53, wd(1, 0, 0, 0)); smp(5000, 5000);
    cur = "R3"; wr(54, wd(0, 0, 0, 45)); smp(4000, -4000); smp(123, 77);
    cur = "R5"; cyc(1, 2000, 2000, 1, 55, wd(1, 0, 0, 51));
    cur = "R4"; smp(2000, 2000); smp(-3001, 1777);
    cur = "R9"; wr(54, wd(1, 0, 0, 0)); smp(30000, 9999);
    wr(55, wd(1, 0, 0, 20)); smp(-30000, 12345); smp(1, -1);

    cur = "R6"; wr(54, wd(0, 1, 0, 57)); wr(55, wd(1, 1, 0, 63));
    smp(100, 100); smp(200, 300);
    smp(-50, 400);
    smp(-60, 0);
    smp(-70, 500);
    cur = "R6"; wr(54, wd(1, 1, 0, 30));
    cyc(1, 80, 40, 1, 55, wd(1, 1, 0, 10));
    smp(90, 41); smp(-5, 42); smp(-6, -43); smp(7, 8);

    cur = "R7"; wr(54, wd(0, 1, 0, 40)); wr(55, wd(1, 1, 0, 50));
    for (int i = 0; i < TO + 3; i++) smp(300, -300);

    cur = "R8"; wr(54, wd(0, 0, 1, 40)); smp(1000, 1000); smp(-2000, -2000);
    wr(54, wd(0, 0, 0, 40)); smp(1000, 1000);

    cur = "R10"; wr(55, wd(0, 0, 0, 63)); wr(54, wd(1, 0, 0, 63));
    smp(32767, -32768); smp(20000, -20000); smp(16000, -16500);
    idle(); idle();
    check("R11", ql.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule